// File: doc/BRIEF.md
# Eight-Channel Capture/Compare Timer

This block is a timer peripheral for a larger chip. A 16-bit free-running count drives eight channels. Each channel is set by software as either a capture channel or a compare channel. A capture channel watches one input pin. It stores the current count in its channel register when that pin makes the transition chosen by the channel's two-bit edge code. A compare channel applies a two-bit pin action to its output pin whenever the count equals its channel register, and it raises a sticky event flag.

Software can also fire any compare channel's action at once through a pulse-only trigger register. The result is the same as a count match in that cycle. A single global run bit gates the count, all captures and all matches. Every register is reached over a simple single-cycle bus. Writes take effect at the clock edge and reads return data combinationally.

Register addresses (5-bit): 0x00 control (bit 7 = run), 0x01 direction, 0x02 upper edge codes, 0x03 lower edge codes, 0x04 upper action codes, 0x05 lower action codes, 0x06 trigger, 0x07 flags, 0x08 count (read-only), 0x10+n channel n register. Unlisted addresses read zero.

Top module: `tmr_capcmp_unit`

## Requirements
- R1: After reset the count is 0. Each clock edge with the run bit set adds one to it, and it goes from 0xFFFF to 0x0000.
- R2: With the run bit clear, the count holds its value and no capture or compare match takes place.
- R3: Channel n has a two-bit edge code, upper bit B and lower bit A. Channels 7..4 live in register 0x02 and channels 3..0 in register 0x03, with the higher channel in the higher bit pair. Code 00 disables capture, 01 captures on a rising edge, 10 on a falling edge, and 11 on either edge.
- R4: Each pin passes through a two-flop synchroniser. A pin change set up before clock edge k stores the count value present after edge k+1, and that value is stored at edge k+2.
- R5: In register 0x01, bit n = 0 makes channel n a capture channel and bit n = 1 makes it a compare channel. A compare channel ignores its pin.
- R6: When the run bit is set and the count equals a compare channel's register, the channel's action is applied to its pin and its flag (register 0x07 bit n) is set at the next edge.
- R7: Channel n has a two-bit action code at the same bit positions as its edge code, in registers 0x04 and 0x05. The codes are 00 = pin unchanged, 01 = toggle, 10 = drive 0, 11 = drive 1.
- R8: Writing 1 to bit n of register 0x06 makes a compare channel n act exactly as on a match in that write's edge, even with the run bit clear. Zero bits and capture channels are unaffected, and the register reads 0.
- R9: Writing 1 to a flag bit clears it and writing 0 leaves it alone. A flag set and a clear in the same cycle leave the flag set.
- R10: After reset every register, every channel register and every output pin is 0. A bus write to address 0x10+n loads channel n and reads back.
- R11: Only bit 7 of register 0x00 is stored. The other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data |
| cap_pin | input | 8 | Capture inputs, one per channel |
| cmp_pin | output | 8 | Compare outputs, one per channel |

## Verification
A wrong synchroniser depth or edge qualification shows up as a stored capture value that is off by one or more counts. It can be seen at the first register read after the third edge. A bad compare or trigger path gives a pin transition in the wrong cycle or of the wrong kind. The pin scoreboard catches this at the first transition it did not expect. Corrupt flag or run-bit state shows on the next read of the flags or the count, within a cycle of the fault.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int NCH    = 8;
    localparam int CNT_W  = 16;
    localparam int ADDR_W = 5;
    localparam int CODE_W = 2;
    localparam int HALF   = NCH / 2;

    localparam logic [ADDR_W-1:0] A_CTRL  = 5'h00;
    localparam logic [ADDR_W-1:0] A_DIR   = 5'h01;
    localparam logic [ADDR_W-1:0] A_EDG_H = 5'h02;
    localparam logic [ADDR_W-1:0] A_EDG_L = 5'h03;
    localparam logic [ADDR_W-1:0] A_ACT_H = 5'h04;
    localparam logic [ADDR_W-1:0] A_ACT_L = 5'h05;
    localparam logic [ADDR_W-1:0] A_TRIG  = 5'h06;
    localparam logic [ADDR_W-1:0] A_FLAG  = 5'h07;
    localparam logic [ADDR_W-1:0] A_CNT   = 5'h08;

    typedef enum logic [1:0] {
        ACT_NONE = 2'b00,
        ACT_TGL  = 2'b01,
        ACT_CLR  = 2'b10,
        ACT_SET  = 2'b11
    } act_e;

    typedef struct packed {
        logic                     run;
        logic [NCH-1:0]           dir;
        logic [CODE_W*NCH-1:0]    edg;
        logic [CODE_W*NCH-1:0]    act;
    } cfg_t;

    typedef struct packed {
        logic [1:0]       sync;
        logic             prev;
        logic [CNT_W-1:0] value;
        logic             pin;
        logic             flag;
    } chan_t;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    output logic [W-1:0] count
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (run) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> cnt_q == $past(cnt_q) + 1'b1);
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              is_cmp,
    input  logic [CODE_W-1:0] edge_sel,
    input  logic [CODE_W-1:0] act_sel,
    input  logic [W-1:0]      count,
    input  logic              pin_in,
    input  logic              wr_val,
    input  logic [W-1:0]      wdata,
    input  logic              trig,
    input  logic              flag_clr,
    output logic [W-1:0]      value,
    output logic              pin_out,
    output logic              flag
);
    chan_t s_d, s_q;
    logic  rise, fall, hit, cap_ev, cmp_ev;

    always_comb begin
        rise   = s_q.sync[1] & ~s_q.prev;
        fall   = ~s_q.sync[1] & s_q.prev;
        hit    = (edge_sel[0] & rise) | (edge_sel[1] & fall);
        cap_ev = run & ~is_cmp & hit;
        cmp_ev = is_cmp & ((run & (count == s_q.value)) | trig);

        s_d      = s_q;
        s_d.sync = {s_q.sync[0], pin_in};
        s_d.prev = s_q.sync[1];
        if (wr_val)      s_d.value = wdata;
        else if (cap_ev) s_d.value = count;
        if (cmp_ev) begin
            unique case (act_e'(act_sel))
                ACT_TGL:  s_d.pin = ~s_q.pin;
                ACT_CLR:  s_d.pin = 1'b0;
                ACT_SET:  s_d.pin = 1'b1;
                default:  s_d.pin = s_q.pin;
            endcase
        end
        if (cmp_ev)        s_d.flag = 1'b1;
        else if (flag_clr) s_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign value   = s_q.value;
    assign pin_out = s_q.pin;
    assign flag    = s_q.flag;

    a_r6_match_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (run && is_cmp && count == value) |=> flag);
    a_r8_trig_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && is_cmp) |=> flag);
    a_r7_clear_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && is_cmp && act_sel == 2'b10) |=> !pin_out);
    a_r7_set_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && is_cmp && act_sel == 2'b11) |=> pin_out);
    a_r5_cmp_keeps_value: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmp && !wr_val) |=> $stable(value));
    a_r2_no_capture_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_val) |=> $stable(value));
    a_r9_clear_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !is_cmp) |=> !flag);
    a_r4_capture_count: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_ev && !wr_val) |=> value == $past(count));
endmodule

// File: rtl/tmr_capcmp_unit.sv
module tmr_capcmp_unit
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [4:0]        bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic [7:0]        cap_pin,
    output logic [7:0]        cmp_pin
);
    localparam int HALF_W = CODE_W * HALF;

    cfg_t           cfg_d, cfg_q;
    logic [CNT_W-1:0] count;
    logic [NCH-1:0] wr_val, trig, flag_clr, flags;
    logic [CNT_W-1:0] chan_val [NCH];

    always_comb begin
        cfg_d = cfg_q;
        if (bus_we) begin
            unique case (bus_addr)
                A_CTRL:  cfg_d.run = bus_wdata[7];
                A_DIR:   cfg_d.dir = bus_wdata[NCH-1:0];
                A_EDG_H: cfg_d.edg[CODE_W*NCH-1:HALF_W] = bus_wdata[HALF_W-1:0];
                A_EDG_L: cfg_d.edg[HALF_W-1:0]          = bus_wdata[HALF_W-1:0];
                A_ACT_H: cfg_d.act[CODE_W*NCH-1:HALF_W] = bus_wdata[HALF_W-1:0];
                A_ACT_L: cfg_d.act[HALF_W-1:0]          = bus_wdata[HALF_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        trig     = (bus_we && bus_addr == A_TRIG) ? bus_wdata[NCH-1:0] : '0;
        flag_clr = (bus_we && bus_addr == A_FLAG) ? bus_wdata[NCH-1:0] : '0;
        for (int n = 0; n < NCH; n++)
            wr_val[n] = bus_we && bus_addr[4] && !bus_addr[3] && (bus_addr[2:0] == n[2:0]);
    end

    tmr_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (cfg_q.run),
        .count (count)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        tmr_channel #(.W(CNT_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (cfg_q.run),
            .is_cmp   (cfg_q.dir[n]),
            .edge_sel (cfg_q.edg[CODE_W*n +: CODE_W]),
            .act_sel  (cfg_q.act[CODE_W*n +: CODE_W]),
            .count    (count),
            .pin_in   (cap_pin[n]),
            .wr_val   (wr_val[n]),
            .wdata    (bus_wdata),
            .trig     (trig[n]),
            .flag_clr (flag_clr[n]),
            .value    (chan_val[n]),
            .pin_out  (cmp_pin[n]),
            .flag     (flags[n])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr[4]) begin
            if (!bus_addr[3]) bus_rdata = chan_val[bus_addr[2:0]];
        end else begin
            unique case (bus_addr)
                A_CTRL:  bus_rdata[7] = cfg_q.run;
                A_DIR:   bus_rdata[NCH-1:0] = cfg_q.dir;
                A_EDG_H: bus_rdata[HALF_W-1:0] = cfg_q.edg[CODE_W*NCH-1:HALF_W];
                A_EDG_L: bus_rdata[HALF_W-1:0] = cfg_q.edg[HALF_W-1:0];
                A_ACT_H: bus_rdata[HALF_W-1:0] = cfg_q.act[CODE_W*NCH-1:HALF_W];
                A_ACT_L: bus_rdata[HALF_W-1:0] = cfg_q.act[HALF_W-1:0];
                A_FLAG:  bus_rdata[NCH-1:0] = flags;
                A_CNT:   bus_rdata = count;
                default: bus_rdata = '0;
            endcase
        end
    end

    a_r8_trig_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == A_TRIG |-> bus_rdata == '0);
    a_r11_ctrl_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == A_CTRL |-> bus_rdata[6:0] == '0);
    a_r2_idle_pins_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q.run && !(bus_we && bus_addr == A_TRIG)) |=> $stable(cmp_pin));
endmodule

// File: tb/tb_tmr_capcmp_unit.sv
`timescale 1ns/100ps
module tb_tmr_capcmp_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [7:0]  cap_pin = '0;
    logic [7:0]  cmp_pin;

    int total = 0;
    int bad = 0;
    logic [7:0] pin_q[$];
    logic [7:0] last_pin = '0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tmr_capcmp_unit dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cap_pin(cap_pin), .cmp_pin(cmp_pin)
    );

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic rd_chk(input logic [4:0] a, input logic [15:0] exp, input string req);
        logic [15:0] v;
        rd(a, v);
        check(v === exp, req, v, exp);
    endtask

    // scoreboard monitor: every pin transition must match the next expected value
    always @(negedge clk) begin
        if (rst_n && cmp_pin !== last_pin) begin
            total++;
            if (pin_q.size() == 0) begin
                bad++;
                $display("FAIL R6/R7/R8 pin actual=0x%02h expected=0x%02h (no change due)", cmp_pin, last_pin);
            end else begin
                logic [7:0] e;
                e = pin_q.pop_front();
                if (cmp_pin !== e) begin
                    bad++;
                    $display("FAIL R6/R7/R8 pin actual=0x%02h expected=0x%02h", cmp_pin, e);
                end
            end
            last_pin = cmp_pin;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=0x0000 expected=0x0001");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] c, c2, base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        rd_chk(5'h00, 16'h0000, "R10 ctrl");
        rd_chk(5'h08, 16'h0000, "R10 count");
        rd_chk(5'h10, 16'h0000, "R10 ch0");
        rd_chk(5'h07, 16'h0000, "R10 flags");
        check(cmp_pin === 8'h00, "R10 pins", {8'h0, cmp_pin}, 16'h0);
        repeat (4) @(negedge clk);
        rd_chk(5'h08, 16'h0000, "R2 count idle");

        // R11 / R1 run bit and stepping
        wr(5'h00, 16'h00FF);
        rd_chk(5'h00, 16'h0080, "R11 ctrl readback");
        rd(5'h08, c);
        rd(5'h08, c2);
        check(c2 === c + 16'd1, "R1 step", c2, c + 16'd1);

        // R3 edge layout
        wr(5'h01, 16'h0000);
        wr(5'h02, 16'h005A);
        wr(5'h03, 16'h005F);
        rd_chk(5'h02, 16'h005A, "R3 upper readback");
        rd_chk(5'h03, 16'h005F, "R3 lower readback");

        // R4 rising capture on ch7, ch5 (falling only) ignores it
        @(negedge clk);
        cap_pin[7] = 1'b1; cap_pin[5] = 1'b1;
        @(negedge clk);
        rd(5'h08, c);
        rd_chk(5'h17, c, "R4 ch7 rising capture");
        rd_chk(5'h15, 16'h0000, "R3 ch5 ignores rising");

        // falling: ch5 captures, ch7 keeps
        @(negedge clk);
        cap_pin[7] = 1'b0; cap_pin[5] = 1'b0;
        @(negedge clk);
        rd(5'h08, c2);
        rd_chk(5'h15, c2, "R3 ch5 falling capture");
        rd_chk(5'h17, c, "R3 ch7 ignores falling");

        // any edge on ch0
        @(negedge clk);
        cap_pin[0] = 1'b1;
        @(negedge clk);
        rd(5'h08, c);
        rd_chk(5'h10, c, "R3 ch0 any-edge rise");

        // R2 no capture while stopped
        wr(5'h00, 16'h0000);
        @(negedge clk);
        cap_pin[0] = 1'b0;
        repeat (5) @(negedge clk);
        rd_chk(5'h10, c, "R2 no capture idle");
        rd(5'h08, c2);
        repeat (3) @(negedge clk);
        rd_chk(5'h08, c2, "R2 count holds");

        // R6 / R7 compare matches
        wr(5'h00, 16'h0080);
        wr(5'h01, 16'h000F);
        wr(5'h05, 16'h002D);
        rd(5'h08, base);
        wr(5'h10, base + 16'd14);
        wr(5'h11, base + 16'd16);
        rd_chk(5'h10, base + 16'd14, "R10 channel write");
        pin_q.push_back(8'h01);
        pin_q.push_back(8'h03);
        repeat (20) @(negedge clk);
        check(pin_q.size() == 0, "R6 matches seen", 16'(pin_q.size()), 16'h0);
        rd_chk(5'h07, 16'h0003, "R6 flags set");

        // R9 flag clearing
        wr(5'h07, 16'h0001);
        rd_chk(5'h07, 16'h0002, "R9 clear bit0");
        wr(5'h07, 16'h0000);
        rd_chk(5'h07, 16'h0002, "R9 zero write keeps");

        // R8 trigger: ch0 toggles, ch4 (capture) unaffected
        pin_q.push_back(8'h02);
        wr(5'h06, 16'h0011);
        rd_chk(5'h07, 16'h0003, "R8 trigger flag, capture ch unaffected");
        rd_chk(5'h06, 16'h0000, "R8 trigger reads zero");
        check(cmp_pin === 8'h02, "R8 trigger toggle", {8'h0, cmp_pin}, 16'h0002);

        // R8 trigger while stopped; R7 clear action; none action
        wr(5'h00, 16'h0000);
        pin_q.push_back(8'h03);
        wr(5'h06, 16'h0001);
        check(cmp_pin === 8'h03, "R8 trigger when stopped", {8'h0, cmp_pin}, 16'h0003);
        wr(5'h05, 16'h0029);
        pin_q.push_back(8'h01);
        wr(5'h06, 16'h0002);
        check(cmp_pin === 8'h01, "R7 clear action", {8'h0, cmp_pin}, 16'h0001);
        wr(5'h07, 16'h00FF);
        wr(5'h06, 16'h0008);
        check(cmp_pin === 8'h01, "R7 none action pin", {8'h0, cmp_pin}, 16'h0001);
        rd_chk(5'h07, 16'h0008, "R7 none action flag");

        // R5 compare channel ignores its pin
        wr(5'h00, 16'h0080);
        @(negedge clk);
        cap_pin[0] = 1'b1;
        repeat (5) @(negedge clk);
        rd_chk(5'h10, base + 16'd14, "R5 compare ignores pin");

        // R1 wrap
        wr(5'h01, 16'h0000);
        rd(5'h08, c);
        repeat (int'(17'h0FFFF - {1'b0, c}) - 1) @(negedge clk);
        rd_chk(5'h08, 16'hFFFF, "R1 top value");
        rd_chk(5'h08, 16'h0000, "R1 wrap to zero");

        check(pin_q.size() == 0, "R6 scoreboard drained", 16'(pin_q.size()), 16'h0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule